// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block sits behind a simple valid/ready register port and turns each access to its single 32-bit word into at most one 8-bit NAND flash bus cycle. A write word carries three things: a chip-enable flag, a three-bit operation code and a data byte. Depending on the code, the bridge runs a command-latch cycle, an address-latch cycle or a data-write cycle on the flash pins, or it only arms read mode.

A register read always reports the synchronized ready/busy state of the flash. While read mode is armed, each register read also runs one read-enable strobe and returns the fetched byte. Strobe low and high times are parameter cycle counts. The port's ready signal is a one-cycle acknowledge that comes only after the whole strobe has finished. The requester holds valid until it sees ready and then drops it.

Top module: `nand_reg_bridge`

## Requirements
- R1: Out of reset, CE#, WE# and RE# are high, CLE, ALE and the data-bus output-enable are low, and ready is low.
- R2: A write with code 0 (bits 30:28) runs a command-latch cycle. CLE is high and ALE is low throughout. WE# is low for LOW_CYC cycles and then high for HIGH_CYC cycles. The data output carries the byte from bits 23:16, and the output-enable is high.
- R3: A write with code 1 runs the same cycle as R2, except that ALE is high and CLE is low.
- R4: A write with code 3 runs the same cycle as R2, except that CLE and ALE are both low.
- R5: A write with code 2 arms read mode. It causes no WE# or RE# strobe, it does not raise the output-enable, and it is acknowledged one cycle after acceptance.
- R6: While read mode is armed, each register read runs one RE# pulse, low for LOW_CYC cycles and then high for HIGH_CYC cycles. The read returns in bits 23:16 the byte present on the flash data input at the end of the low phase.
- R7: Bit 15 of every register read is 1 when the flash R/B# input is low (busy) and 0 when it is high. The input passes through a two-flop synchronizer before it is reported.
- R8: CE# is driven low exactly when bit 31 of the most recent write was 1. Reads never change it.
- R9: A write with code 4, 5, 6 or 7 runs no flash cycle, never raises the output-enable, and is acknowledged one cycle after acceptance. It only updates the chip-enable state.
- R10: A write of any code other than 2 disarms read mode. A read while disarmed runs no RE# pulse, returns 0 in bits 23:16, and is acknowledged one cycle after acceptance.
- R11: Ready is a single-cycle pulse. It stays low while any strobe is in progress, and a strobed access is acknowledged LOW_CYC+HIGH_CYC+1 cycles after acceptance. Read-data bits other than 23:16 and 15 are zero.
- R12: The output-enable is never high while RE# is low, and WE# and RE# are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| req_ready | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 32 | Read word, valid while ready is high on a read |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output-enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bench builds the bridge with LOW_CYC=2 and HIGH_CYC=3. These values are different from each other, so a swapped or off-by-one phase length changes the acknowledge latency and the strobe width that the bench counts. It sweeps all eight operation codes with both chip-enable values and a spread of data bytes. It then runs a series of reads in read mode with a different byte on the data input for each read, and finishes by driving the R/B# input in both directions.

// File: rtl/nrb_pkg.sv
package nrb_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2,
      PH_ACK  = 2'd3
   } nrb_phase_e;

   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_CMD   = 3'd1,
      K_ADDR  = 3'd2,
      K_WDATA = 3'd3,
      K_RDATA = 3'd4
   } nrb_kind_e;

   localparam logic [2:0] OPC_CMD   = 3'd0;
   localparam logic [2:0] OPC_ADDR  = 3'd1;
   localparam logic [2:0] OPC_ARM   = 3'd2;
   localparam logic [2:0] OPC_WDATA = 3'd3;

   function automatic nrb_kind_e write_kind(input logic [2:0] opc);
      case (opc)
         OPC_CMD:   write_kind = K_CMD;
         OPC_ADDR:  write_kind = K_ADDR;
         OPC_WDATA: write_kind = K_WDATA;
         default:   write_kind = K_NONE;
      endcase
   endfunction

   function automatic logic drives_bus(input nrb_kind_e k);
      drives_bus = (k == K_CMD) || (k == K_ADDR) || (k == K_WDATA);
   endfunction

endpackage

// File: rtl/nrb_sync.sv
module nrb_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nrb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nrb_timer.sv
module nrb_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   if (CW < 1) begin : g_bad_cw
      $error("nrb_timer: CW must be positive");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/nrb_seq.sv
module nrb_seq
   import nrb_pkg::*;
#(
   parameter int LOW_CYC  = 2,
   parameter int HIGH_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       strobe,
   output nrb_phase_e phase,
   output logic       low_done
);
   localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] LOW_LD  = CW'(LOW_CYC - 1);
   localparam logic [CW-1:0] HIGH_LD = CW'(HIGH_CYC - 1);

   if (LOW_CYC < 1 || HIGH_CYC < 1) begin : g_bad_timing
      $error("nrb_seq: strobe phases need at least one cycle");
   end

   logic          t_zero;
   logic          t_load;
   logic [CW-1:0] t_val;
   logic          go_low;

   assign go_low   = (phase == PH_IDLE) && start && strobe;
   assign low_done = (phase == PH_LOW) && t_zero;
   assign t_load   = go_low || low_done;
   assign t_val    = go_low ? LOW_LD : HIGH_LD;

   nrb_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else begin
         case (phase)
            PH_IDLE: if (start) phase <= strobe ? PH_LOW : PH_ACK;
            PH_LOW:  if (t_zero) phase <= PH_HIGH;
            PH_HIGH: if (t_zero) phase <= PH_ACK;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R11: acknowledge lasts exactly one cycle
   a_r11_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ACK) |=> (phase == PH_IDLE));

   // R11: a strobe always passes through its high phase before the acknowledge
   a_r11_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
      low_done |=> (phase == PH_HIGH));
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
   import nrb_pkg::*;
#(
   parameter int LOW_CYC     = 2,
   parameter int HIGH_CYC    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int BUS_W       = 32,
   parameter int DQ_W        = 8,
   parameter int CE_BIT      = 31,
   parameter int OP_LSB      = 28,
   parameter int DATA_LSB    = 16,
   parameter int BUSY_BIT    = 15
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [31:0] req_wdata,
   output logic        req_ready,
   output logic [31:0] rsp_rdata,
   output logic        nand_ce_n,
   output logic        nand_cle,
   output logic        nand_ale,
   output logic        nand_we_n,
   output logic        nand_re_n,
   output logic [7:0]  nand_dq_out,
   output logic        nand_dq_oe,
   input  logic [7:0]  nand_dq_in,
   input  logic        nand_rb_n
);
   localparam int OP_W     = 3;
   localparam int DATA_MSB = DATA_LSB + DQ_W - 1;

   if (BUS_W != 32 || DQ_W != 8) begin : g_bad_width
      $error("nand_reg_bridge: port widths are fixed at 32 and 8");
   end
   if (CE_BIT >= BUS_W || OP_LSB + OP_W > BUS_W || DATA_MSB >= BUS_W) begin : g_bad_field
      $error("nand_reg_bridge: field outside the register word");
   end
   if (BUSY_BIT >= DATA_LSB && BUSY_BIT <= DATA_MSB) begin : g_bad_busy
      $error("nand_reg_bridge: busy bit overlaps the data field");
   end

   nrb_phase_e        phase;
   logic              low_done;
   logic              accept;
   nrb_kind_e         kind_d, kind_q;
   logic              ce_q, rd_mode_q, is_read_q;
   logic [DQ_W-1:0]   wbyte_q, rbyte_q;
   logic [OP_W-1:0]   opc;
   logic              rb_sync;
   logic              in_strobe;
   logic              unused_wbits;

   assign opc          = req_wdata[OP_LSB +: OP_W];
   assign accept       = req_valid && (phase == PH_IDLE);
   assign unused_wbits = ^{req_wdata[27:24], req_wdata[15:0]};

   always_comb begin
      if (req_write)      kind_d = write_kind(opc);
      else if (rd_mode_q) kind_d = K_RDATA;
      else                kind_d = K_NONE;
   end

   nrb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nand_rb_n),
      .q     (rb_sync)
   );

   nrb_seq #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .strobe   (kind_d != K_NONE),
      .phase    (phase),
      .low_done (low_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q      <= 1'b0;
         rd_mode_q <= 1'b0;
         is_read_q <= 1'b0;
         kind_q    <= K_NONE;
         wbyte_q   <= '0;
      end else if (accept) begin
         kind_q    <= kind_d;
         is_read_q <= !req_write;
         if (req_write) begin
            ce_q      <= req_wdata[CE_BIT];
            rd_mode_q <= (opc == OPC_ARM);
            wbyte_q   <= req_wdata[DATA_LSB +: DQ_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rbyte_q <= '0;
      else if (accept)                         rbyte_q <= '0;
      else if (low_done && kind_q == K_RDATA)  rbyte_q <= nand_dq_in;
   end

   assign in_strobe   = (phase == PH_LOW) || (phase == PH_HIGH);
   assign nand_ce_n   = !ce_q;
   assign nand_cle    = in_strobe && (kind_q == K_CMD);
   assign nand_ale    = in_strobe && (kind_q == K_ADDR);
   assign nand_we_n   = !((phase == PH_LOW) && drives_bus(kind_q));
   assign nand_re_n   = !((phase == PH_LOW) && (kind_q == K_RDATA));
   assign nand_dq_oe  = in_strobe && drives_bus(kind_q);
   assign nand_dq_out = wbyte_q;
   assign req_ready   = (phase == PH_ACK);

   always_comb begin
      rsp_rdata = '0;
      if (req_ready && is_read_q) begin
         rsp_rdata[DATA_LSB +: DQ_W] = rbyte_q;
         rsp_rdata[BUSY_BIT]         = !rb_sync;
      end
   end

   // R12: the two strobes never overlap
   a_r12_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   // R12: the data bus is released while the flash drives it
   a_r12_no_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe);

   // R2, R3: command and address latches never rise together
   a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   // R2: the output byte holds still while WE# is low and into the rising edge
   a_r2_dq_held: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |=> $stable(nand_dq_out));

   // R11: no acknowledge while a strobe is low
   a_r11_no_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !req_ready);

   // R11: ready is a single-cycle pulse
   a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   // R8: chip enable moves only on an accepted write
   a_r8_ce_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && req_write) |=> $stable(nand_ce_n));

   // R6, R10: the read strobe appears only with read mode armed
   a_r10_re_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> rd_mode_q);
endmodule

// File: tb/sim_nand_reg_bridge.sv
module sim_nand_reg_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int LOWC  = 2;
   localparam int HIGHC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic [31:0] rsp_rdata;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_out;
   logic [7:0]  nand_dq_in = 8'h00;
   logic        nand_rb_n = 1'b1;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_reg_bridge #(.LOW_CYC(LOWC), .HIGH_CYC(HIGHC)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_rdata(rsp_rdata),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
      .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Runs one access from a negedge and watches the pins until the acknowledge.
   task automatic access(input bit wr, input logic [31:0] wd,
                         output logic [31:0] rd, output int cyc,
                         output int we_lo, output int re_lo, output int oe_cnt,
                         output logic [2:0] sig, output logic [7:0] dq);
      bit first = 1'b1;
      rd = '0; cyc = 0; we_lo = 0; re_lo = 0; oe_cnt = 0; sig = '0; dq = '0;
      req_valid = 1'b1; req_write = wr; req_wdata = wd;
      while (cyc < 1000) begin
         @(negedge clk);
         cyc++;
         if (!nand_we_n) begin
            we_lo++;
            if (first) begin
               sig = {nand_cle, nand_ale, nand_dq_oe};
               dq = nand_dq_out;
               first = 1'b0;
            end
         end
         if (!nand_re_n) re_lo++;
         if (nand_dq_oe) oe_cnt++;
         if (req_ready) begin
            rd = rsp_rdata;
            break;
         end
      end
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      int cyc, we_lo, re_lo, oe_cnt;
      logic [2:0] sig;
      logic [7:0] dq;

      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 ce_n", 32'(nand_ce_n), 32'd1);
      chk("R1 we_n/re_n", {30'd0, nand_we_n, nand_re_n}, 32'd3);
      chk("R1 cle/ale/oe", {29'd0, nand_cle, nand_ale, nand_dq_oe}, 32'd0);
      chk("R1 ready", 32'(req_ready), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: read before any write, read mode disarmed
      access(1'b0, 32'h0, rd, cyc, we_lo, re_lo, oe_cnt, sig, dq);
      chk("R10 idle read latency", 32'(cyc), 32'd1);
      chk("R10 idle read no RE#", 32'(re_lo), 32'd0);
      chk("R10 idle read byte", {24'd0, rd[23:16]}, 32'd0);
      @(negedge clk);

      // Sweep all opcodes, both chip-enable values and varied bytes
      for (int op = 0; op < 8; op++) begin
         for (int c = 0; c < 2; c++) begin
            logic [7:0] b;
            bit strobed;
            b = 8'((op * 37) + (c * 91) + 5);
            strobed = (op == 0) || (op == 1) || (op == 3);
            access(1'b1, {c[0], op[2:0], 4'h0, b, 16'h0}, rd, cyc, we_lo, re_lo, oe_cnt, sig, dq);
            if (strobed) begin
               chk("R11 strobed write latency", 32'(cyc), 32'(LOWC + HIGHC + 1));
               chk("R2 WE# low width", 32'(we_lo), 32'(LOWC));
               chk("R2 oe span", 32'(oe_cnt), 32'(LOWC + HIGHC));
               chk("R2 data byte", {24'd0, dq}, {24'd0, b});
               if (op == 0) chk("R2 cle/ale/oe", {29'd0, sig}, 32'b101);
               if (op == 1) chk("R3 cle/ale/oe", {29'd0, sig}, 32'b011);
               if (op == 3) chk("R4 cle/ale/oe", {29'd0, sig}, 32'b001);
            end else if (op == 2) begin
               chk("R5 arm latency", 32'(cyc), 32'd1);
               chk("R5 arm no strobe", 32'(we_lo + re_lo), 32'd0);
               chk("R5 arm no oe", 32'(oe_cnt), 32'd0);
            end else begin
               chk("R9 other op latency", 32'(cyc), 32'd1);
               chk("R9 other op no strobe", 32'(we_lo + re_lo), 32'd0);
               chk("R9 other op no oe", 32'(oe_cnt), 32'd0);
            end
            chk("R12 no RE# during write", 32'(re_lo), 32'd0);
            @(negedge clk);
            chk("R8 ce_n follows bit 31", 32'(nand_ce_n), 32'(!c[0]));
         end
      end

      // Arm read mode with CE set, then read several bytes
      access(1'b1, {1'b1, 3'd2, 28'h0}, rd, cyc, we_lo, re_lo, oe_cnt, sig, dq);
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         nand_dq_in = 8'(8'hA5 ^ (k * 29));
         access(1'b0, 32'h0, rd, cyc, we_lo, re_lo, oe_cnt, sig, dq);
         chk("R6 read byte", {24'd0, rd[23:16]}, {24'd0, 8'(8'hA5 ^ (k * 29))});
         chk("R6 RE# low width", 32'(re_lo), 32'(LOWC));
         chk("R11 read latency", 32'(cyc), 32'(LOWC + HIGHC + 1));
         chk("R12 no oe/WE# on read", 32'(oe_cnt + we_lo), 32'd0);
         chk("R11 unused bits zero", rd & 32'hFF00_7FFF, 32'd0);
         chk("R8 ce_n held across reads", 32'(nand_ce_n), 32'd0);
         @(negedge clk);
      end

      // R10: a write of code 5 disarms read mode
      access(1'b1, {1'b1, 3'd5, 28'h0}, rd, cyc, we_lo, re_lo, oe_cnt, sig, dq);
      @(negedge clk);
      nand_dq_in = 8'h3C;
      access(1'b0, 32'h0, rd, cyc, we_lo, re_lo, oe_cnt, sig, dq);
      chk("R10 disarmed no RE#", 32'(re_lo), 32'd0);
      chk("R10 disarmed byte zero", {24'd0, rd[23:16]}, 32'd0);
      chk("R10 disarmed latency", 32'(cyc), 32'd1);
      @(negedge clk);

      // R7: busy reporting through the synchronizer
      nand_rb_n = 1'b0;
      repeat (4) @(negedge clk);
      access(1'b0, 32'h0, rd, cyc, we_lo, re_lo, oe_cnt, sig, dq);
      chk("R7 busy bit set", 32'(rd[15]), 32'd1);
      chk("R11 unused bits zero busy", rd & 32'hFF00_7FFF, 32'd0);
      @(negedge clk);
      nand_rb_n = 1'b1;
      repeat (4) @(negedge clk);
      access(1'b0, 32'h0, rd, cyc, we_lo, re_lo, oe_cnt, sig, dq);
      chk("R7 busy bit clear", 32'(rd[15]), 32'd0);
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule